// File: doc/BRIEF.md
# TDM Audio Transmit Serializer

This block turns audio sample words into one serial data line organised as a time-division-multiplexed frame of one to eight slots. A separate clock and frame unit supplies a one-cycle bit strobe for every serial bit time. It also raises a frame strobe together with the bit strobe on the first bit of each frame. The serializer counts bits and slots from those strobes. At the first bit of each enabled slot it picks up a sample word and shifts out the formatted slot, one bit per strobe.

Software or a DMA engine writes words into a one-deep holding register through a ready/valid handshake. Each word is formatted by configuration inputs:

- sample width;
- position of the sample inside the written word and inside the slot;
- the value used to fill unused slot bits;
- bit order on the line.

Two stereo options reuse one word for both slots of a left/right pair. In packed stereo, the left sample is in the low half and the right sample in the high half. In mono, the left sample is sent in both slots. If a slot needs a word and the holding register is empty, the block raises a sticky underrun flag and sends either zeros or the previous word again. Slots can be switched off one by one. A disabled slot drives a selectable idle level, or releases the line through its output enable.

Top module: `tdm_tx_serializer`

## Requirements
- R1: `wr_ready` is high exactly when the holding register is empty. A write is taken on a clock where `wr_valid` and `wr_ready` are both high, and `wr_ready` is low on the following cycle.
- R2: On the first bit of an enabled slot that takes a word, a full holding register moves into the slot word and `wr_ready` is high again on the next cycle. A word written in that same cycle counts for a later slot. Odd slots take no word when `cfg_mono` is set or when packed stereo is selected.
- R3: A cycle with `bit_stb` and `frame_stb` high is bit 0 of slot 0. Each later `bit_stb` advances one bit. The slot length comes from `cfg_slot_size` (0:8, 1:16, 2:24, 3:32 bits), and the frame has `cfg_slots`+1 slots. `sd_out` and `sd_oe` are registered on the `bit_stb` cycle and hold until the next strobe.
- R4: `cfg_word_size` selects the sample width (0:8, 1:16, 2:18, 3:20, 4:24, 5:32, 6:packed 8+8, 7:packed 16+16). For codes 0 to 5 the sample is taken from the low bits of the word, or from its top bits when `cfg_word_left` is 1.
- R5: With `cfg_slot_left` at 1 the sample fills the high end of the slot, otherwise the low end. The remaining slot bits are filled according to `cfg_pad`: 0 gives zeros, 1 gives ones, 2 copies the sample MSB and 3 copies the sample LSB.
- R6: The slot is sent from its highest bit down, or from bit 0 up when `cfg_lsb_first` is 1.
- R7: In packed stereo (codes 6 and 7), the even slot sends the low half or byte of the word and the following odd slot sends the next half or byte up.
- R8: With `cfg_mono` at 1, an odd slot sends the same formatted sample as its even slot.
- R9: `underrun` is set when a slot needs a word and the holding register is empty. It stays set until a cycle with `urun_clr` high and no new underrun. It is low after reset.
- R10: On underrun the slot word becomes zero, or keeps the previous word when `cfg_urun_last` is 1.
- R11: A slot whose bit in `cfg_slot_off` is 1 takes no word and drives an idle level given by `cfg_idle`: 0 drives low, 1 drives high, 2 or 3 drives `sd_oe` low with `sd_out` low. Enabled slots drive `sd_oe` high. Before the first frame strobe the line is also idle.
- R12: After reset `sd_out` and `sd_oe` are low, `wr_ready` is high and `underrun` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_stb | input | 1 | One-cycle strobe per serial bit time |
| frame_stb | input | 1 | With bit_stb, marks bit 0 of slot 0 |
| cfg_slots | input | 3 | Slots per frame minus one |
| cfg_slot_size | input | 2 | Slot length code |
| cfg_word_size | input | 3 | Sample width or packed stereo code |
| cfg_word_left | input | 1 | Sample sits at the top of the written word |
| cfg_slot_left | input | 1 | Sample sits at the top of the slot |
| cfg_lsb_first | input | 1 | Send slot bit 0 first |
| cfg_pad | input | 2 | Fill source for unused slot bits |
| cfg_mono | input | 1 | Repeat the left sample in odd slots |
| cfg_urun_last | input | 1 | Repeat previous word on underrun |
| cfg_slot_off | input | 8 | Per-slot disable, bit n for slot n |
| cfg_idle | input | 2 | Line level in disabled slots |
| wr_data | input | 32 | Sample word to hold |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Holding register empty |
| urun_clr | input | 1 | Clears the underrun flag |
| underrun | output | 1 | Sticky underrun flag |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Serial data output enable |

## Verification
Some properties are checked on every clock:

- the handshake closing after a write and reopening after a load;
- the underrun flag rising after an empty-slot event and staying set until cleared;
- the line holding still between strobes;
- disabled slots driving exactly the idle level, and enabled slots driving the line.

The bit values on the line can only be shown by the bench scenarios. Each scenario compares the stream against an independent model of formatting, bit order, packed and mono pairing, and the zero or repeat fill policy. These scenarios cover many slot and word combinations.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

  localparam int WORD_W    = 32;
  localparam int BIT_IDX_W = $clog2(WORD_W);

  localparam logic [1:0] PAD_ZERO = 2'd0;
  localparam logic [1:0] PAD_ONE  = 2'd1;
  localparam logic [1:0] PAD_MSB  = 2'd2;

  // sample width in bits for each word-size code
  function automatic int word_bits(input logic [2:0] ws);
    case (ws)
      3'd0:    return 8;
      3'd1:    return 16;
      3'd2:    return 18;
      3'd3:    return 20;
      3'd4:    return 24;
      3'd5:    return 32;
      3'd6:    return 8;
      default: return 16;
    endcase
  endfunction

  function automatic int slot_bits(input logic [1:0] ss);
    return 8 * (int'(ss) + 1);
  endfunction

  function automatic logic is_packed(input logic [2:0] ws);
    return ws[2] & ws[1];
  endfunction

  // Formats one slot and returns it left-aligned in send order.
  function automatic logic [WORD_W-1:0] build_tx(
    input logic [WORD_W-1:0] word,
    input logic              right,
    input logic [2:0]        ws,
    input logic [1:0]        ss,
    input logic              word_left,
    input logic              slot_left,
    input logic [1:0]        pad,
    input logic              lsb_first
  );
    int w, s, base, off;
    logic [WORD_W-1:0] smp, img, tx;
    logic pbit;
    w = word_bits(ws);
    s = slot_bits(ss);
    if (is_packed(ws)) base = right ? w : 0;
    else               base = word_left ? WORD_W - w : 0;
    if (w > s) w = s;
    smp = word >> base;
    if (pad == PAD_ZERO)     pbit = 1'b0;
    else if (pad == PAD_ONE) pbit = 1'b1;
    else if (pad == PAD_MSB) pbit = smp[w-1];
    else                     pbit = smp[0];
    off = slot_left ? s - w : 0;
    for (int i = 0; i < WORD_W; i++) begin
      if (i >= off && i < off + w) img[i] = smp[i-off];
      else                         img[i] = pbit;
    end
    tx = '0;
    for (int k = 0; k < WORD_W; k++) begin
      if (k < s) tx[WORD_W-1-k] = lsb_first ? img[k] : img[s-1-k];
    end
    return tx;
  endfunction

endpackage

// File: rtl/tdm_tx_position.sv
module tdm_tx_position
  import tdm_tx_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int SLOT_IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_stb,
  input  logic                  frame_stb,
  input  logic [SLOT_IDX_W-1:0] cfg_slots,
  input  logic [1:0]            cfg_slot_size,
  output logic [SLOT_IDX_W-1:0] cur_slot,
  output logic [BIT_IDX_W-1:0]  cur_bit,
  output logic                  pos_valid,
  output logic                  slot_start
);

  logic [SLOT_IDX_W-1:0] last_slot;
  logic [BIT_IDX_W-1:0]  last_bit;
  logic                  sync_q;
  int                    s_bits;

  always_comb begin
    s_bits = slot_bits(cfg_slot_size);
    if (frame_stb) begin
      cur_slot = '0;
      cur_bit  = '0;
    end else if (int'(last_bit) >= s_bits - 1) begin
      cur_bit  = '0;
      cur_slot = (last_slot >= cfg_slots) ? '0 : last_slot + 1'b1;
    end else begin
      cur_bit  = last_bit + 1'b1;
      cur_slot = last_slot;
    end
  end

  assign pos_valid  = frame_stb | sync_q;
  assign slot_start = bit_stb & pos_valid & (cur_bit == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_slot <= '0;
      last_bit  <= '0;
      sync_q    <= 1'b0;
    end else if (bit_stb) begin
      last_slot <= cur_slot;
      last_bit  <= cur_bit;
      sync_q    <= sync_q | frame_stb;
    end
  end

endmodule

// File: rtl/tdm_tx_holding.sv
module tdm_tx_holding
  import tdm_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              take,
  input  logic              cfg_urun_last,
  input  logic              urun_clr,
  output logic [WORD_W-1:0] word_sel,
  output logic              load_ev,
  output logic              urun_ev,
  output logic              underrun
);

  logic              hold_full;
  logic [WORD_W-1:0] hold_q, word_q;

  assign wr_ready = ~hold_full;
  assign load_ev  = take & hold_full;
  assign urun_ev  = take & ~hold_full;

  always_comb begin
    if (load_ev)                      word_sel = hold_q;
    else if (urun_ev && !cfg_urun_last) word_sel = '0;
    else                              word_sel = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
      word_q    <= '0;
      underrun  <= 1'b0;
    end else begin
      if (wr_valid && !hold_full) begin
        hold_q    <= wr_data;
        hold_full <= 1'b1;
      end else if (load_ev) begin
        hold_full <= 1'b0;
      end
      if (take) word_q <= word_sel;
      underrun <= urun_ev | (underrun & ~urun_clr);
    end
  end

endmodule

// File: rtl/tdm_tx_format.sv
module tdm_tx_format
  import tdm_tx_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              right,
  input  logic [2:0]        cfg_word_size,
  input  logic [1:0]        cfg_slot_size,
  input  logic              cfg_word_left,
  input  logic              cfg_slot_left,
  input  logic [1:0]        cfg_pad,
  input  logic              cfg_lsb_first,
  output logic [WORD_W-1:0] tx_img
);

  assign tx_img = build_tx(word, right, cfg_word_size, cfg_slot_size,
                           cfg_word_left, cfg_slot_left, cfg_pad, cfg_lsb_first);

endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer
  import tdm_tx_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int SLOT_IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_stb,
  input  logic                  frame_stb,
  input  logic [SLOT_IDX_W-1:0] cfg_slots,
  input  logic [1:0]            cfg_slot_size,
  input  logic [2:0]            cfg_word_size,
  input  logic                  cfg_word_left,
  input  logic                  cfg_slot_left,
  input  logic                  cfg_lsb_first,
  input  logic [1:0]            cfg_pad,
  input  logic                  cfg_mono,
  input  logic                  cfg_urun_last,
  input  logic [NUM_SLOTS-1:0]  cfg_slot_off,
  input  logic [1:0]            cfg_idle,
  input  logic [WORD_W-1:0]     wr_data,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic                  urun_clr,
  output logic                  underrun,
  output logic                  sd_out,
  output logic                  sd_oe
);

  logic [SLOT_IDX_W-1:0] cur_slot;
  logic [BIT_IDX_W-1:0]  cur_bit;
  logic                  pos_valid, slot_start;
  logic                  slot_en, slot_odd, shares_word, take, chan_right;
  logic                  load_ev, urun_ev;
  logic [WORD_W-1:0]     word_sel, tx_img, shift_q;
  logic                  idle_oe, idle_d;

  tdm_tx_position #(.NUM_SLOTS(NUM_SLOTS)) u_pos (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .frame_stb(frame_stb),
    .cfg_slots(cfg_slots), .cfg_slot_size(cfg_slot_size),
    .cur_slot(cur_slot), .cur_bit(cur_bit), .pos_valid(pos_valid),
    .slot_start(slot_start)
  );

  assign slot_en     = ~cfg_slot_off[cur_slot];
  assign slot_odd    = cur_slot[0];
  assign shares_word = slot_odd & (cfg_mono | is_packed(cfg_word_size));
  assign take        = slot_start & slot_en & ~shares_word;
  assign chan_right  = slot_odd & ~cfg_mono;

  tdm_tx_holding u_hold (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .take(take), .cfg_urun_last(cfg_urun_last),
    .urun_clr(urun_clr), .word_sel(word_sel), .load_ev(load_ev),
    .urun_ev(urun_ev), .underrun(underrun)
  );

  tdm_tx_format u_fmt (
    .word(word_sel), .right(chan_right), .cfg_word_size(cfg_word_size),
    .cfg_slot_size(cfg_slot_size), .cfg_word_left(cfg_word_left),
    .cfg_slot_left(cfg_slot_left), .cfg_pad(cfg_pad),
    .cfg_lsb_first(cfg_lsb_first), .tx_img(tx_img)
  );

  assign idle_oe = ~cfg_idle[1];
  assign idle_d  = ~cfg_idle[1] & cfg_idle[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_out  <= 1'b0;
      sd_oe   <= 1'b0;
      shift_q <= '0;
    end else if (bit_stb) begin
      if (!(pos_valid && slot_en)) begin
        sd_out <= idle_d;
        sd_oe  <= idle_oe;
      end else if (cur_bit == '0) begin
        sd_out  <= tx_img[WORD_W-1];
        shift_q <= tx_img << 1;
        sd_oe   <= 1'b1;
      end else begin
        sd_out  <= shift_q[WORD_W-1];
        shift_q <= shift_q << 1;
        sd_oe   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/tdm_tx_checker.sv
module tdm_tx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_stb,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic       urun_clr,
  input logic       underrun,
  input logic       sd_out,
  input logic       sd_oe,
  input logic [1:0] cfg_idle,
  input logic       load_ev,
  input logic       urun_ev,
  input logic       pos_valid,
  input logic       slot_en
);

  p_accept_closes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> !wr_ready);

  p_load_reopens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> wr_ready);

  p_line_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(sd_out) && $stable(sd_oe));

  p_urun_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    urun_ev |=> underrun);

  p_urun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun && !urun_clr |=> underrun);

  p_idle_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb && !(pos_valid && slot_en) |=>
      (sd_oe == !$past(cfg_idle[1])) && (sd_out == (!$past(cfg_idle[1]) && $past(cfg_idle[0]))));

  p_active_drives_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb && pos_valid && slot_en |=> sd_oe);

endmodule

bind tdm_tx_serializer tdm_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .urun_clr(urun_clr), .underrun(underrun),
  .sd_out(sd_out), .sd_oe(sd_oe), .cfg_idle(cfg_idle), .load_ev(load_ev),
  .urun_ev(urun_ev), .pos_valid(pos_valid), .slot_en(slot_en)
);

// File: tb/sim_tdm_tx_serializer.sv
module sim_tdm_tx_serializer;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        bit_stb = 0, frame_stb = 0;
  logic [2:0]  cfg_slots = 3'd1;
  logic [1:0]  cfg_slot_size = 2'd3;
  logic [2:0]  cfg_word_size = 3'd5;
  logic        cfg_word_left = 0, cfg_slot_left = 0, cfg_lsb_first = 0;
  logic [1:0]  cfg_pad = 2'd0;
  logic        cfg_mono = 0, cfg_urun_last = 0;
  logic [7:0]  cfg_slot_off = 8'h00;
  logic [1:0]  cfg_idle = 2'd0;
  logic [31:0] wr_data = '0;
  logic        wr_valid = 0, urun_clr = 0;
  logic        wr_ready, underrun, sd_out, sd_oe;

  tdm_tx_serializer u0 (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .frame_stb(frame_stb),
    .cfg_slots(cfg_slots), .cfg_slot_size(cfg_slot_size),
    .cfg_word_size(cfg_word_size), .cfg_word_left(cfg_word_left),
    .cfg_slot_left(cfg_slot_left), .cfg_lsb_first(cfg_lsb_first),
    .cfg_pad(cfg_pad), .cfg_mono(cfg_mono), .cfg_urun_last(cfg_urun_last),
    .cfg_slot_off(cfg_slot_off), .cfg_idle(cfg_idle), .wr_data(wr_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .urun_clr(urun_clr),
    .underrun(underrun), .sd_out(sd_out), .sd_oe(sd_oe)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_tag = "R12";

  logic  exp_d[$];
  logic  exp_oe[$];
  string exp_tag[$];
  logic [31:0] feedq[$];

  // bench model state
  bit          m_full = 0, m_urun = 0, m_en = 0;
  logic [31:0] m_hold = '0, m_word = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares the line one cycle after every strobe
  logic mon_due = 0;
  always @(posedge clk) mon_due <= bit_stb;
  always @(negedge clk) begin
    if (mon_due && !done) begin
      if (exp_d.size() == 0) chk("R3 unexpected strobe result", 1, 0);
      else begin
        logic d, oe;
        string t;
        d = exp_d.pop_front(); oe = exp_oe.pop_front(); t = exp_tag.pop_front();
        chk({t, " line"}, {30'd0, sd_oe, sd_out}, {30'd0, oe, d});
      end
    end
  end

  function automatic int wbits(input logic [2:0] ws);
    case (ws)
      3'd0: return 8;  3'd1: return 16; 3'd2: return 18; 3'd3: return 20;
      3'd4: return 24; 3'd5: return 32; 3'd6: return 8;  default: return 16;
    endcase
  endfunction

  // expected k-th sent bit of a slot, from R4..R8
  function automatic logic model_bit(input logic [31:0] word, input bit right, input int k);
    int w, s, base, p, off;
    bit pk;
    logic pb;
    w  = wbits(cfg_word_size);
    s  = 8 * (int'(cfg_slot_size) + 1);
    pk = (cfg_word_size >= 3'd6);
    if (pk) base = right ? w : 0;
    else    base = cfg_word_left ? 32 - w : 0;
    p = cfg_lsb_first ? k : s - 1 - k;
    case (cfg_pad)
      2'd0: pb = 1'b0;
      2'd1: pb = 1'b1;
      2'd2: pb = word[base + w - 1];
      default: pb = word[base];
    endcase
    off = cfg_slot_left ? s - w : 0;
    if (p >= off && p < off + w) return word[base + p - off];
    return pb;
  endfunction

  task automatic feed();
    if (!m_full && feedq.size() > 0) begin
      logic [31:0] w;
      w = feedq.pop_front();
      chk("R1 ready while empty", {31'd0, wr_ready}, 1);
      wr_data = w; wr_valid = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0;
      m_hold = w; m_full = 1;
      chk("R1 ready after write", {31'd0, wr_ready}, 0);
    end
  endtask

  task automatic do_bit(input int s, input int b);
    bit right;
    right = (s % 2) == 1;
    @(negedge clk);
    if (b == 0) begin
      m_en = !cfg_slot_off[s];
      if (m_en && !(right && (cfg_mono || cfg_word_size >= 3'd6))) begin
        if (m_full) begin m_word = m_hold; m_full = 0; end
        else begin m_urun = 1; if (!cfg_urun_last) m_word = '0; end
      end
    end
    exp_tag.push_back(cur_tag);
    if (m_en) begin
      exp_d.push_back(model_bit(m_word, right && !cfg_mono, b));
      exp_oe.push_back(1'b1);
    end else begin
      exp_d.push_back(!cfg_idle[1] && cfg_idle[0]);
      exp_oe.push_back(!cfg_idle[1]);
    end
    bit_stb = 1'b1;
    frame_stb = (s == 0 && b == 0);
    @(negedge clk);
    bit_stb = 1'b0;
    frame_stb = 1'b0;
  endtask

  task automatic run_frame();
    @(negedge clk);
    feed();
    for (int s = 0; s <= int'(cfg_slots); s++) begin
      for (int b = 0; b < 8 * (int'(cfg_slot_size) + 1); b++) begin
        do_bit(s, b);
        if (b == 0) begin
          chk("R2 ready follows load", {31'd0, wr_ready}, {31'd0, !m_full});
          feed();
        end
      end
    end
    @(negedge clk);
    chk("R9 underrun flag", {31'd0, underrun}, {31'd0, m_urun});
  endtask

  task automatic clear_urun();
    @(negedge clk); urun_clr = 1'b1;
    @(negedge clk); urun_clr = 1'b0;
    m_urun = 0;
    chk("R9 cleared", {31'd0, underrun}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 sd_out", {31'd0, sd_out}, 0);
    chk("R12 sd_oe", {31'd0, sd_oe}, 0);
    chk("R12 wr_ready", {31'd0, wr_ready}, 1);
    chk("R12 underrun", {31'd0, underrun}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // two 32-bit slots, plain 32-bit words, MSB first
    cur_tag = "R3/R4 plain";
    for (int i = 0; i < 5; i++) feedq.push_back(32'h8123_4567 ^ (i * 32'h1111_0001));
    run_frame(); run_frame();

    // eight 16-bit slots, LSB first, slots 3 and 5 off
    cur_tag = "R6/R11 lsb first idle high";
    cfg_slots = 3'd7; cfg_slot_size = 2'd1; cfg_word_size = 3'd1;
    cfg_slot_left = 1; cfg_lsb_first = 1; cfg_pad = 2'd1;
    cfg_slot_off = 8'b0010_1000; cfg_idle = 2'd1;
    for (int i = 0; i < 14; i++) feedq.push_back(32'hA5C3_0000 + i * 32'h0001_0F0F);
    run_frame();
    cur_tag = "R11 idle released";
    cfg_idle = 2'd2;
    run_frame();

    // 20-bit sample from the top of the word in 24-bit slots
    cur_tag = "R4/R5 pad msb";
    cfg_slots = 3'd1; cfg_slot_size = 2'd2; cfg_word_size = 3'd3;
    cfg_word_left = 1; cfg_slot_left = 0; cfg_lsb_first = 0; cfg_pad = 2'd2;
    cfg_slot_off = 8'h00; cfg_idle = 2'd0;
    for (int i = 0; i < 6; i++) feedq.push_back(32'h9E37_79B9 + i * 32'h7000_1234);
    run_frame();
    cur_tag = "R5 pad one left slot";
    cfg_pad = 2'd1; cfg_slot_left = 1;
    run_frame();
    cur_tag = "R5 pad lsb";
    cfg_pad = 2'd3; cfg_word_left = 0; cfg_word_size = 3'd0;
    run_frame();

    // packed 16+16 stereo, then packed 8+8 over four slots
    cur_tag = "R7 packed16";
    cfg_word_size = 3'd7; cfg_slot_size = 2'd1; cfg_pad = 2'd0; cfg_slot_left = 0;
    feedq.delete();
    for (int i = 0; i < 3; i++) feedq.push_back(32'hBEEF_1357 + i * 32'h0102_0304);
    run_frame();
    cur_tag = "R7 packed8";
    cfg_word_size = 3'd6; cfg_slot_size = 2'd0; cfg_slots = 3'd3;
    for (int i = 0; i < 4; i++) feedq.push_back(32'h0000_C35A + i * 32'h0000_1111);
    run_frame();

    // mono 24-bit sample in 32-bit slots
    cur_tag = "R8 mono";
    cfg_word_size = 3'd4; cfg_slot_size = 2'd3; cfg_slots = 3'd3;
    cfg_mono = 1; cfg_pad = 2'd3; cfg_slot_left = 1;
    feedq.delete();
    for (int i = 0; i < 4; i++) feedq.push_back(32'h00D1_2345 + i * 32'h0011_0001);
    run_frame();

    // underrun with zero fill
    cur_tag = "R10 zero fill";
    cfg_mono = 0; cfg_word_size = 3'd5; cfg_slots = 3'd2; cfg_pad = 2'd0;
    feedq.delete();
    run_frame();
    chk("R9 sticky after frame", {31'd0, underrun}, 1);
    clear_urun();

    // underrun repeating the previous word
    cur_tag = "R10 repeat last";
    cfg_urun_last = 1; cfg_slots = 3'd1;
    feedq.push_back(32'hF00D_CAFE);
    run_frame();
    clear_urun();

    // disabled slots keep the held word
    cur_tag = "R11 no take when off";
    cfg_urun_last = 0; cfg_slot_off = 8'h03; cfg_idle = 2'd0;
    feedq.push_back(32'h1357_9BDF);
    run_frame();
    chk("R11 word still held", {31'd0, wr_ready}, 0);
    cur_tag = "R2 held word sent";
    cfg_slot_off = 8'h02;
    run_frame();

    repeat (4) @(negedge clk);
    chk("R3 no leftover", exp_d.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule